// File: doc/BRIEF.md
# Arrival-Order Exchange Arbiter

This block schedules the source side of an all-to-all exchange among N processing nodes, as used when a matrix held in row slices across the nodes is redistributed into column slices. Each node raises its request line when its output buffer is ready. The arbiter admits the nodes into an arrival queue, so a node that became ready earlier is served earlier. Nodes that become ready in the same cycle are ordered by a rotating pointer. The pointer moves on after every tie, which spreads the benefit of a tie evenly over the nodes.

The node at the head of the queue gets a one-hot grant. It keeps that grant while it sends one sub-block to each destination in turn. The destination index output tells the data path which destination is current. The index starts at node 0 and advances once for every sub-transfer done pulse. After the done pulse for the last destination, the grant is released and the next queued node is granted. Each node is served at most once per phase. When all N nodes have finished their sweeps, a one-cycle phase-complete pulse is produced, and a restart pulse opens the next phase. Moving the data and generating the buffer addresses are handled outside this block.

Top module: `xchg_arbiter`

## Requirements
- R1: After a synchronous reset, `grant` is all zeros, `dest_idx` is 0 and `phase_done` is 0.
- R2: A node whose request is first sampled high in an earlier cycle is granted before a node whose request is first sampled high in a later cycle.
- R3: Nodes first sampled high in the same cycle are granted in order of rising index, starting at a rotating pointer and wrapping from N-1 to 0. The pointer is 0 after reset. After any cycle in which two or more nodes arrive, the pointer becomes (first node of that batch + 1) mod N. A lone arrival leaves the pointer unchanged, and restart keeps it.
- R4: `grant` is one-hot, with bit i meaning node i. When the arbiter is idle and the queue is empty, a request first sampled at clock edge k produces the grant after edge k+1.
- R5: While a grant is held, `dest_idx` begins at 0 and rises by one on each edge at which `sub_done` is high. `grant` and `dest_idx` stay unchanged on edges at which `sub_done` is low.
- R6: The edge that samples `sub_done` while `dest_idx` is N-1 clears `grant` and `dest_idx`. If another node is already queued, that node is granted at the next edge.
- R7: A node is admitted at most once per phase. Its request line has no effect after admission, including after its sweep has finished and including after the line drops and rises again, until `restart`.
- R8: `phase_done` is high for exactly one cycle, in the cycle right after the edge that ends the N-th sweep of the phase.
- R9: `restart`, sampled at an edge, clears the grant, the queue and the record of admitted nodes. Requests sampled at that same edge are ignored.
- R10: `sub_done` has no effect while no grant is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Pulse that opens a new exchange phase |
| req | input | N_NODES | Per-node ready level, bit i = node i |
| sub_done | input | 1 | One pulse per completed sub-block transfer |
| grant | output | N_NODES | One-hot source grant |
| dest_idx | output | $clog2(N_NODES) | Current destination node index |
| phase_done | output | 1 | One-cycle pulse when every node has finished its sweep |

## Verification
The case of interest is when the release of a finished sweep falls in the same cycle as a batch of new requests, so that queue admission and grant hand-over happen at one edge. The bench provokes this by raising two request lines in the same cycle as the final `sub_done` of the current sweep. It then expects `grant` to be zero for exactly one sampled cycle, and after that expects the tie-winner chosen by the rotating pointer, followed by the other node. Table-driven tie patterns step the pointer through several start positions, and directed tests cover latency, repeated requests, restart in the middle of a sweep, and stray `sub_done` pulses.

// File: rtl/xa_pkg.sv
package xa_pkg;

  typedef int unsigned uint_t;

  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_HOLD = 1'b1
  } sweep_state_e;

  // (a + b) mod n for a < n and b <= n
  function automatic uint_t wrap_add(uint_t a, uint_t b, uint_t n);
    uint_t s;
    s = a + b;
    return (s >= n) ? s - n : s;
  endfunction

endpackage

// File: rtl/xa_arrival.sv
module xa_arrival #(
  parameter int N_NODES = 4,
  parameter int IDX_W   = 2,
  parameter int CNT_W   = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           restart,
  input  logic [N_NODES-1:0]             req,
  output logic [CNT_W-1:0]               push_cnt,
  output logic [N_NODES-1:0][IDX_W-1:0]  push_list
);
  import xa_pkg::*;

  logic [N_NODES-1:0] seen_q;
  logic [IDX_W-1:0]   rr_q;
  logic [N_NODES-1:0] fresh;
  logic [IDX_W-1:0]   node;
  logic [CNT_W-1:0]   slot;

  assign fresh = req & ~seen_q;

  // order same-cycle arrivals starting at the rotating pointer
  always_comb begin
    slot      = '0;
    push_list = '0;
    node      = '0;
    for (int k = 0; k < N_NODES; k++) begin
      node = IDX_W'(wrap_add(uint_t'(rr_q), uint_t'(k), uint_t'(N_NODES)));
      if (fresh[node]) begin
        push_list[slot] = node;
        slot            = slot + 1'b1;
      end
    end
  end

  assign push_cnt = restart ? '0 : slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      rr_q   <= '0;
    end else if (restart) begin
      seen_q <= '0;
    end else begin
      seen_q <= seen_q | fresh;
      if (slot >= CNT_W'(2))
        rr_q <= IDX_W'(wrap_add(uint_t'(push_list[0]), 1, uint_t'(N_NODES)));
    end
  end

endmodule

// File: rtl/xa_order_fifo.sv
module xa_order_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  parameter int CNT_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic [CNT_W-1:0]           push_cnt,
  input  logic [DEPTH-1:0][W-1:0]    push_list,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic                       empty
);
  import xa_pkg::*;

  logic [W-1:0]     mem [DEPTH];
  logic [W-1:0]     rptr_q;
  logic [W-1:0]     wptr_q;
  logic [CNT_W-1:0] count_q;

  // multi-entry write: up to DEPTH indices in one cycle
  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (uint_t'(k) < uint_t'(push_cnt))
        mem[W'(wrap_add(uint_t'(wptr_q), uint_t'(k), uint_t'(DEPTH)))] <= push_list[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rptr_q  <= '0;
      wptr_q  <= '0;
      count_q <= '0;
    end else begin
      wptr_q  <= W'(wrap_add(uint_t'(wptr_q), uint_t'(push_cnt), uint_t'(DEPTH)));
      if (pop)
        rptr_q <= W'(wrap_add(uint_t'(rptr_q), 1, uint_t'(DEPTH)));
      count_q <= count_q + push_cnt - CNT_W'(pop);
    end
  end

  assign head  = mem[rptr_q];
  assign empty = (count_q == '0);

endmodule

// File: rtl/xa_sweep.sv
module xa_sweep #(
  parameter int N_NODES = 4,
  parameter int IDX_W   = 2,
  parameter int CNT_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic               sub_done,
  input  logic               q_empty,
  input  logic [IDX_W-1:0]   q_head,
  output logic               pop,
  output logic [N_NODES-1:0] grant,
  output logic [IDX_W-1:0]   dest_idx,
  output logic               phase_done
);
  import xa_pkg::*;

  localparam logic [IDX_W-1:0] LAST_DEST = IDX_W'(N_NODES - 1);
  localparam logic [CNT_W-1:0] LAST_SRC  = CNT_W'(N_NODES - 1);

  sweep_state_e       state_q;
  logic [CNT_W-1:0]   fin_q;

  assign pop = (state_q == SW_IDLE) && !q_empty && !restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SW_IDLE;
      grant      <= '0;
      dest_idx   <= '0;
      fin_q      <= '0;
      phase_done <= 1'b0;
    end else begin
      phase_done <= 1'b0;
      if (restart) begin
        state_q  <= SW_IDLE;
        grant    <= '0;
        dest_idx <= '0;
        fin_q    <= '0;
      end else begin
        case (state_q)
          SW_IDLE: begin
            if (!q_empty) begin
              grant    <= N_NODES'(1) << q_head;
              dest_idx <= '0;
              state_q  <= SW_HOLD;
            end
          end
          SW_HOLD: begin
            if (sub_done) begin
              if (dest_idx == LAST_DEST) begin
                grant      <= '0;
                dest_idx   <= '0;
                state_q    <= SW_IDLE;
                fin_q      <= fin_q + 1'b1;
                phase_done <= (fin_q == LAST_SRC);
              end else begin
                dest_idx <= dest_idx + 1'b1;
              end
            end
          end
          default: state_q <= SW_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/xchg_arbiter.sv
module xchg_arbiter #(
  parameter  int N_NODES = 4,
  localparam int IDX_W   = (N_NODES > 1) ? $clog2(N_NODES) : 1,
  localparam int CNT_W   = $clog2(N_NODES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [N_NODES-1:0] req,
  input  logic               sub_done,
  output logic [N_NODES-1:0] grant,
  output logic [IDX_W-1:0]   dest_idx,
  output logic               phase_done
);

  logic [CNT_W-1:0]              push_cnt;
  logic [N_NODES-1:0][IDX_W-1:0] push_list;
  logic                          pop;
  logic [IDX_W-1:0]              q_head;
  logic                          q_empty;

  xa_arrival #(.N_NODES(N_NODES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_arrival (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .req       (req),
    .push_cnt  (push_cnt),
    .push_list (push_list)
  );

  xa_order_fifo #(.DEPTH(N_NODES), .W(IDX_W), .CNT_W(CNT_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (restart),
    .push_cnt  (push_cnt),
    .push_list (push_list),
    .pop       (pop),
    .head      (q_head),
    .empty     (q_empty)
  );

  xa_sweep #(.N_NODES(N_NODES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_sweep (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .sub_done   (sub_done),
    .q_empty    (q_empty),
    .q_head     (q_head),
    .pop        (pop),
    .grant      (grant),
    .dest_idx   (dest_idx),
    .phase_done (phase_done)
  );

endmodule

// File: rtl/xa_checker.sv
module xa_checker #(
  parameter  int N_NODES = 4,
  localparam int IDX_W   = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               restart,
  input logic               sub_done,
  input logic [N_NODES-1:0] grant,
  input logic [IDX_W-1:0]   dest_idx,
  input logic               phase_done
);

  localparam logic [IDX_W-1:0] LAST_DEST = IDX_W'(N_NODES - 1);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && !sub_done && !restart) |=> ($stable(grant) && $stable(dest_idx))); // R5

  AST_DEST_STEP: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && sub_done && dest_idx != LAST_DEST && !restart)
      |=> (dest_idx == $past(dest_idx) + IDX_W'(1) && $stable(grant))); // R5

  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && sub_done && dest_idx == LAST_DEST && !restart)
      |=> (grant == '0 && dest_idx == '0)); // R6

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart |=> (grant == '0)); // R9

  AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (grant == '0) |-> (dest_idx == '0)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    phase_done |=> !phase_done); // R8

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    phase_done |-> (grant == '0)); // R8

endmodule

bind xchg_arbiter xa_checker #(.N_NODES(N_NODES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .restart    (restart),
  .sub_done   (sub_done),
  .grant      (grant),
  .dest_idx   (dest_idx),
  .phase_done (phase_done)
);

// File: tb/tb_xchg_arbiter.sv
`timescale 1ns/1ps
module tb_xchg_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         restart = 1'b0;
  logic [N-1:0] req = '0;
  logic         sub_done = 1'b0;
  logic [N-1:0] grant;
  logic [1:0]   dest_idx;
  logic         phase_done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xchg_arbiter #(.N_NODES(N)) dut (
    .clk(clk), .rst(rst), .restart(restart), .req(req), .sub_done(sub_done),
    .grant(grant), .dest_idx(dest_idx), .phase_done(phase_done)
  );

  // {mask[3:0], count[2:0], order[7:0]} ; order slot0 in bits [1:0]
  localparam logic [14:0] VEC [6] = '{
    {4'b1111, 3'd4, 8'b11_10_01_00},
    {4'b1111, 3'd4, 8'b00_11_10_01},
    {4'b0101, 3'd2, 8'b00_00_00_10},
    {4'b1000, 3'd1, 8'b00_00_00_11},
    {4'b0011, 3'd2, 8'b00_00_01_00},
    {4'b1110, 3'd3, 8'b00_11_10_01}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic pulse_restart();
    req = '0;
    restart = 1'b1;
    tick();
    restart = 1'b0;
  endtask

  // serve one node's sweep; raise extra requests together with its last done
  task automatic sweep(input int node, input bit exp_pd, input logic [N-1:0] raise_last,
                       input string tag);
    int w = 0;
    while (grant == '0 && w < 20) begin tick(); w++; end
    check(grant == N'(1 << node), tag, int'(grant), 1 << node);
    for (int d = 0; d < N; d++) begin
      check(dest_idx == 2'(d), "R5 dest_idx", int'(dest_idx), d);
      check(grant == N'(1 << node), "R5 grant held", int'(grant), 1 << node);
      sub_done = 1'b1;
      if (d == N - 1) req = req | raise_last;
      tick();
      sub_done = 1'b0;
    end
    check(grant == '0, "R6 release", int'(grant), 0);
    check(phase_done == exp_pd, "R8 phase_done", int'(phase_done), int'(exp_pd));
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1
    check(grant == '0, "R1 grant", int'(grant), 0);
    check(dest_idx == '0, "R1 dest_idx", int'(dest_idx), 0);
    check(phase_done == 1'b0, "R1 phase_done", int'(phase_done), 0);

    // R3 table of same-cycle patterns; pointer walks 0->1->2->3->3->1->2
    for (int e = 0; e < 6; e++) begin
      logic [3:0] m;
      int cnt;
      m   = VEC[e][14:11];
      cnt = int'(VEC[e][10:8]);
      pulse_restart();
      req = m;
      for (int s = 0; s < cnt; s++) begin
        int nd;
        nd = int'(VEC[e][2*s +: 2]);
        sweep(nd, (m == 4'b1111) && (s == cnt - 1), '0, "R3 tie order");
      end
      if (m == 4'b1111) begin
        tick();
        check(phase_done == 1'b0, "R8 single pulse", int'(phase_done), 0);
      end
    end

    // R4 latency with idle arbiter and empty queue
    pulse_restart();
    req = 4'b0010;
    tick();
    check(grant == '0, "R4 not yet", int'(grant), 0);
    tick();
    check(grant == 4'b0010, "R4 grant after two edges", int'(grant), 2);
    sweep(1, 1'b0, '0, "R4 sweep");

    // R2 arrival order beats index order
    pulse_restart();
    req = 4'b1000;
    tick();
    req = 4'b1001;
    sweep(3, 1'b0, '0, "R2 earlier first");
    sweep(0, 1'b0, '0, "R2 later second");

    // R7 repeated requests of finished nodes are ignored
    for (int i = 0; i < 5; i++) begin
      tick();
      check(grant == '0, "R7 held request ignored", int'(grant), 0);
    end
    req[3] = 1'b0;
    tick();
    req[3] = 1'b1;
    tick(); tick(); tick();
    check(grant == '0, "R7 re-raised request ignored", int'(grant), 0);

    // R6 release coinciding with a tie batch; pointer 2 -> order 2,3
    pulse_restart();
    req = 4'b0010;
    sweep(1, 1'b0, 4'b1100, "R6 first sweep");
    tick();
    check(grant == 4'b0100, "R6 next grant at following edge", int'(grant), 4);
    sweep(2, 1'b0, '0, "R3 tie winner after release");
    sweep(3, 1'b0, '0, "R3 tie second");
    req[0] = 1'b1;
    sweep(0, 1'b1, '0, "R8 last source");

    // R9 restart in mid-sweep; pointer 3 -> order 0,1
    pulse_restart();
    req = 4'b0011;
    tick(); tick();
    check(grant == 4'b0001, "R9 tie winner", int'(grant), 1);
    sub_done = 1'b1;
    tick();
    sub_done = 1'b0;
    check(dest_idx == 2'd1, "R5 advance", int'(dest_idx), 1);
    req = '0;
    restart = 1'b1;
    tick();
    restart = 1'b0;
    check(grant == '0, "R9 grant cleared", int'(grant), 0);
    check(dest_idx == '0, "R9 dest cleared", int'(dest_idx), 0);
    for (int i = 0; i < 4; i++) tick();
    check(grant == '0, "R9 queue flushed", int'(grant), 0);
    req = 4'b0010;
    sweep(1, 1'b0, '0, "R9 record cleared");

    // R10 stray sub_done pulses
    pulse_restart();
    sub_done = 1'b1;
    tick(); tick(); tick();
    check(grant == '0, "R10 no grant", int'(grant), 0);
    req = 4'b0100;
    tick(); tick();
    sub_done = 1'b0;
    check(grant == 4'b0100, "R10 grant", int'(grant), 4);
    check(dest_idx == '0, "R10 dest starts at zero", int'(dest_idx), 0);
    sweep(2, 1'b0, '0, "R10 sweep");

    // R1 reset in mid-sweep
    req = 4'b1000;
    tick(); tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check(grant == '0, "R1 reset clears grant", int'(grant), 0);
    check(dest_idx == '0, "R1 reset clears dest", int'(dest_idx), 0);

    summary();
  end

endmodule